// File: doc/BRIEF.md
# I2C Slave Byte Receiver

This block listens to a two-wire I2C bus from inside a synchronous design that runs on a clock much faster than the bus. It samples the SCL and SDA lines, finds START, repeated START and STOP conditions, and assembles the bits into bytes. The first byte after any START is compared against a configured 7-bit slave address. When that byte names this receiver with the write direction, the receiver acknowledges it and every byte after it by pulling SDA low through an open-drain enable.

Every data byte accepted while the receiver is selected appears on a parallel output together with a strobe that lasts one clock, so that a FIFO or any other byte-wide sink can capture the stream. A transfer carries any number of data bytes and ends at STOP or at the next START. A read request to the receiver's address is recognised but left unacknowledged, because sending data back is not part of this block.

Top module: `i2c_byte_rx`

## Requirements
- R1: SDA falling while SCL is high (START) makes `bus_busy` 1, clears `selected` and begins reception of an address byte.
- R2: SDA rising while SCL is high (STOP) makes `bus_busy` and `selected` 0 and releases `sda_pull`, whatever the state before.
- R3: A START that arrives while the bus is busy (repeated START) deselects the receiver and restarts address reception; the next address byte alone decides selection.
- R4: SDA is taken as data only on a rising edge of SCL; SDA changes while SCL is low have no effect on the received bytes or on any output.
- R5: Each byte is eight bits with the most significant bit first, followed by a ninth clock for the acknowledge.
- R6: When the address byte's upper seven bits equal `own_addr` and its least significant bit is 0 (write), `selected` becomes 1 at the eighth SCL rising edge, and `sda_pull` is 1 from the next SCL falling edge until the SCL falling edge that ends the ninth clock.
- R7: An address byte that does not match, or that carries the read bit 1, leaves `selected` at 0 and produces no `sda_pull` and no `rx_valid` until the next START.
- R8: While selected, each data byte is shown on `rx_data` with `rx_valid` high for exactly one clock at its eighth SCL rising edge, and it is acknowledged with the same `sda_pull` timing as in R6.
- R9: The number of data bytes in one transfer is not limited.
- R10: Reset (`rst_n` low, asynchronous) gives `bus_busy` 0, `selected` 0, `sda_pull` 0 and `rx_valid` 0.
- R11: With the default two synchroniser stages, a bus change that the clock samples at rising edge k shows on the outputs just after rising edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous reset, active low |
| own_addr | input | 7 | Slave address of this receiver |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-clock strobe for `rx_data` |
| bus_busy | output | 1 | 1 between START and STOP |
| selected | output | 1 | 1 while a write to `own_addr` is in progress |

## Verification
The receiver's own acknowledge drive and the master's line changes meet in the same clock window: the receiver pulls SDA while the master releases it, so the bus level it then samples contains its own pull, and a STOP or repeated START can follow one half-clock after the ninth falling edge that releases it. The bench models the bus as a wired AND of the master drive and the receiver's pull, runs a behavioural reference on the same line samples, and compares every output on every clock, so any cycle in which pull release and a new condition overlap is judged by exact cycle agreement. A repeated START placed right after an acknowledged byte and SDA toggling while SCL is low make these overlaps occur.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } rx_phase_e;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    output logic [LINES-1:0] line_now,
    output logic [LINES-1:0] line_prev
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe_d, pipe_q;
        logic              prev_d, prev_q;

        always_comb begin
            pipe_d = {pipe_q[STAGES-2:0], line_in[g]};
            prev_d = pipe_q[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= '1;
                prev_q <= 1'b1;
            end else begin
                pipe_q <= pipe_d;
                prev_q <= prev_d;
            end
        end

        assign line_now[g]  = pipe_q[STAGES-1];
        assign line_prev[g] = prev_q;
    end
endmodule

// File: rtl/i2c_rx_cond.sv
module i2c_rx_cond (
    input  logic scl_now,
    input  logic scl_prev,
    input  logic sda_now,
    input  logic sda_prev,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_held;

    always_comb begin
        scl_held  = scl_now & scl_prev;
        scl_rise  = scl_now & ~scl_prev;
        scl_fall  = ~scl_now & scl_prev;
        start_det = scl_held & sda_prev & ~sda_now;
        stop_det  = scl_held & ~sda_prev & sda_now;
    end
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
    import i2c_rx_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              sda_now,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_pull,
    output logic [ADDR_W:0]   rx_data,
    output logic              rx_valid,
    output logic              bus_busy,
    output logic              selected
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

    typedef struct packed {
        rx_phase_e         ph;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              ack_pend;
        logic              pull;
        logic [BYTE_W-1:0] dat;
        logic              vld;
    } eng_t;

    eng_t              st_d, st_q;
    logic [BYTE_W-1:0] shift_next;

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b0;
        shift_next = {st_q.sh[BYTE_W-2:0], sda_now};
        if (stop_det) begin
            st_d.ph       = PH_IDLE;
            st_d.cnt      = '0;
            st_d.ack_pend = 1'b0;
            st_d.pull     = 1'b0;
        end else if (start_det) begin
            st_d.ph       = PH_ADDR;
            st_d.cnt      = '0;
            st_d.sh       = '0;
            st_d.ack_pend = 1'b0;
            st_d.pull     = 1'b0;
        end else if (st_q.ph != PH_IDLE) begin
            if (scl_rise) begin
                if (st_q.cnt < ACK_SLOT) begin
                    st_d.sh  = shift_next;
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == LAST_BIT) begin
                        case (st_q.ph)
                            PH_ADDR: begin
                                if (shift_next[BYTE_W-1:1] == own_addr && !shift_next[0]) begin
                                    st_d.ph       = PH_DATA;
                                    st_d.ack_pend = 1'b1;
                                end else begin
                                    st_d.ph = PH_SKIP;
                                end
                            end
                            PH_DATA: begin
                                st_d.vld      = 1'b1;
                                st_d.dat      = shift_next;
                                st_d.ack_pend = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end else if (st_q.cnt == ACK_SLOT) begin
                    st_d.cnt = ACK_DONE;
                end
            end else if (scl_fall) begin
                if (st_q.cnt == ACK_SLOT && st_q.ack_pend) begin
                    st_d.pull     = 1'b1;
                    st_d.ack_pend = 1'b0;
                end else if (st_q.cnt == ACK_DONE) begin
                    st_d.pull = 1'b0;
                    st_d.cnt  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, sh: '0, ack_pend: 1'b0,
                      pull: 1'b0, dat: '0, vld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_pull = st_q.pull;
    assign rx_data  = st_q.dat;
    assign rx_valid = st_q.vld;
    assign bus_busy = (st_q.ph != PH_IDLE);
    assign selected = (st_q.ph == PH_DATA);

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7
    strobe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> selected);

    // R2
    stop_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!bus_busy && !selected && !sda_pull));

    // R1
    start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (bus_busy && !selected && !sda_pull));

    // R6
    pull_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));

    // R2
    pull_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> bus_busy);
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic [ADDR_W:0]   rx_data,
    output logic              rx_valid,
    output logic              bus_busy,
    output logic              selected
);
    localparam int LN_SCL = 1;
    localparam int LN_SDA = 0;

    logic [1:0] ln_now, ln_prev;
    logic       scl_rise, scl_fall, start_det, stop_det;

    i2c_rx_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  ({scl_in, sda_in}),
        .line_now (ln_now),
        .line_prev(ln_prev)
    );

    i2c_rx_cond u_cond (
        .scl_now  (ln_now[LN_SCL]),
        .scl_prev (ln_prev[LN_SCL]),
        .sda_now  (ln_now[LN_SDA]),
        .sda_prev (ln_prev[LN_SDA]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_rx_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .own_addr (own_addr),
        .sda_now  (ln_now[LN_SDA]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_pull (sda_pull),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .bus_busy (bus_busy),
        .selected (selected)
    );
endmodule

// File: tb/i2c_byte_rx_tb_top.sv
module i2c_byte_rx_tb_top;
    localparam int Q = 6;
    localparam logic [6:0] MY_ADDR = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       bus_busy;
    logic       selected;
    wire        sda_line = sda_m & ~sda_pull;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    i2c_byte_rx dut_i (
        .clk(clk), .rst_n(rst_n), .own_addr(MY_ADDR),
        .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .rx_data(rx_data), .rx_valid(rx_valid),
        .bus_busy(bus_busy), .selected(selected)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference, fed by the same line samples (R11: two-sample delay)
    logic s1, d1, s2, d2, sp, dp;
    int   m_mode;   // 0 idle, 1 address, 2 writing to us, 3 ignoring
    int   m_bits;
    int   m_byte;
    bit   m_owe, m_pull, m_vld;
    int   m_dat;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1; d1 <= 1; s2 <= 1; d2 <= 1; sp <= 1; dp <= 1;
            m_mode = 0; m_bits = 0; m_byte = 0; m_owe = 0; m_pull = 0; m_vld = 0; m_dat = 0;
        end else begin
            m_vld = 0;
            if (s2 && sp && !dp && d2) begin
                m_mode = 0; m_bits = 0; m_owe = 0; m_pull = 0;
            end else if (s2 && sp && dp && !d2) begin
                m_mode = 1; m_bits = 0; m_byte = 0; m_owe = 0; m_pull = 0;
            end else if (m_mode != 0) begin
                if (s2 && !sp) begin
                    if (m_bits < 8) begin
                        m_byte = ((m_byte << 1) | int'(d2)) & 255;
                        m_bits++;
                        if (m_bits == 8) begin
                            if (m_mode == 1) begin
                                if ((m_byte >> 1) == int'(MY_ADDR) && (m_byte % 2) == 0) begin
                                    m_mode = 2; m_owe = 1;
                                end else m_mode = 3;
                            end else if (m_mode == 2) begin
                                m_vld = 1; m_dat = m_byte; m_owe = 1;
                            end
                        end
                    end else if (m_bits == 8) m_bits = 9;
                end else if (!s2 && sp) begin
                    if (m_bits == 8 && m_owe) begin m_pull = 1; m_owe = 0; end
                    else if (m_bits == 9) begin m_pull = 0; m_bits = 0; end
                end
            end
            s1 <= scl_m; d1 <= sda_line; s2 <= s1; d2 <= d1; sp <= s2; dp <= d2;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(bus_busy == (m_mode != 0), "R1", "bus_busy", bus_busy, m_mode != 0);
            chk(selected == (m_mode == 2), "R6", "selected", selected, m_mode == 2);
            chk(sda_pull == m_pull, "R6", "sda_pull", sda_pull, m_pull);
            chk(rx_valid == m_vld, "R8", "rx_valid", rx_valid, m_vld);
            if (m_vld) chk(rx_data == m_dat[7:0], "R5", "rx_data", rx_data, m_dat);
            if (rx_valid) begin
                if (exp_q.size() == 0) chk(0, "R7", "unexpected byte", rx_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e, "R9", "byte stream", rx_data, e);
                end
            end
        end
    end

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic do_start();
        sda_m = 1; wq(); scl_m = 1; wq();
        sda_m = 0; wq(); scl_m = 0; wq();
    endtask

    task automatic do_stop();
        sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq();
    endtask

    task automatic do_bit(input bit b, input bit glitch, output bit seen);
        if (glitch) begin
            sda_m = ~b; @(negedge clk); sda_m = b; @(negedge clk);
            sda_m = ~b; @(negedge clk);
        end
        sda_m = b; wq(); scl_m = 1; wq(); seen = sda_line; wq(); scl_m = 0; wq();
    endtask

    task automatic do_byte(input logic [7:0] v, input bit glitch, input bit want_ack,
                           input string req);
        bit seen;
        for (int i = 7; i >= 0; i--) do_bit(v[i], glitch, seen);
        do_bit(1'b1, glitch, seen);
        chk((!seen) == want_ack, req, "ack on ninth clock", !seen, want_ack);
    endtask

    initial begin
        bit dummy;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!bus_busy && !selected && !sda_pull && !rx_valid, "R10", "reset outputs",
            {bus_busy, selected, sda_pull, rx_valid}, 0);
        rst_n = 1; repeat (4) @(negedge clk);
        chk(!bus_busy && !selected, "R10", "idle after reset", {bus_busy, selected}, 0);

        // R6 R8 R5: write to own address
        do_start();
        chk(bus_busy && !selected, "R1", "busy after start", {bus_busy, selected}, 2);
        do_byte({MY_ADDR, 1'b0}, 0, 1, "R6");
        exp_q.push_back(8'hA5); do_byte(8'hA5, 0, 1, "R8");
        exp_q.push_back(8'h3C); do_byte(8'h3C, 0, 1, "R8");
        exp_q.push_back(8'h00); do_byte(8'h00, 0, 1, "R5");
        exp_q.push_back(8'hFF); do_byte(8'hFF, 0, 1, "R5");
        do_stop();
        chk(!bus_busy && !selected && !sda_pull, "R2", "idle after stop",
            {bus_busy, selected, sda_pull}, 0);

        // R7: other address, then read to own address
        do_start();
        do_byte({MY_ADDR ^ 7'h01, 1'b0}, 0, 0, "R7");
        do_byte(8'h55, 0, 0, "R7");
        chk(!selected, "R7", "not selected on mismatch", selected, 0);
        do_stop();
        do_start();
        do_byte({MY_ADDR, 1'b1}, 0, 0, "R7");
        do_byte(8'h81, 0, 0, "R7");
        do_stop();

        // R3: repeated starts switch selection
        do_start();
        do_byte({MY_ADDR, 1'b0}, 0, 1, "R6");
        exp_q.push_back(8'h12); do_byte(8'h12, 0, 1, "R8");
        do_start();
        chk(bus_busy && !selected, "R3", "deselected by repeated start", {bus_busy, selected}, 2);
        do_byte({7'h22, 1'b0}, 0, 0, "R3");
        do_byte(8'h77, 0, 0, "R3");
        do_start();
        do_byte({MY_ADDR, 1'b0}, 0, 1, "R3");
        exp_q.push_back(8'hC9); do_byte(8'hC9, 0, 1, "R3");
        // R4: SDA toggling while SCL low
        exp_q.push_back(8'h6B); do_byte(8'h6B, 1, 1, "R4");
        exp_q.push_back(8'h94); do_byte(8'h94, 1, 1, "R4");
        // R9: a long run of bytes in one transfer
        for (int k = 0; k < 14; k++) begin
            logic [7:0] v;
            v = 8'((k * 37 + 11) & 255);
            exp_q.push_back(v); do_byte(v, 0, 1, "R9");
        end
        do_stop();
        do_bit(1'b1, 0, dummy);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "all bytes delivered", exp_q.size(), 0);
        chk(!bus_busy && !sda_pull, "R2", "final idle", {bus_busy, sda_pull}, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule